// File: doc/BRIEF.md
# Multi-port shared EDID memory

This block holds one EDID image that four display-input ports read at the same time. Most of the image is common to every port. Each port also owns three private bytes: a two-byte physical address and a checksum. These are substituted into that port's view of the image, so every input shows its own identity while the bulk of the storage is held only once.

A host write port loads the common image, the substitution pointer and the private bytes. The image is volatile and is reloaded after every power-up. Each display port has its own byte-read interface: an address goes in and the data comes back one cycle later. A separate per-port enable input decides whether that port presents the EDID at all. A port that is not enabled returns all ones and raises a not-present flag, which the serial layer above can use to refuse the transfer. The serial protocol engines and the checksum arithmetic are outside the block; the host supplies every value.

Top module: `edid_multi_port`

## Requirements
- R1: A read address presented on a clock edge returns its byte after that edge, one cycle of latency. Any address other than 255, the pointer and pointer+1 returns the common image byte at that address.
- R2: Reading the address equal to the pointer returns the port's physical address byte 0. Reading pointer+1 (mod 256) returns byte 1. Both apply only when the address is not 255.
- R3: Reading address 255 returns the port's own checksum byte. This takes priority over a pointer match.
- R4: When a port's share_en bit is 0 in the read cycle, it returns 0xFF with absent=1. When the bit is 1, absent=0.
- R5: All four ports read in every cycle without stalling one another. Each port sees only its own private bytes.
- R6: Host writes take effect when host_wr=1, as follows. host_tgt=0 writes host_wdata to the common image at host_addr. host_tgt=1 loads the pointer. host_tgt=2 writes a private byte of port host_port, with host_addr[1:0] choosing the byte: 0 for physical address byte 0, 1 for byte 1, 2 for the checksum. host_addr[1:0]=3 and host_tgt=3 change nothing.
- R7: A host write and a port read in the same cycle return the state from before the write. This covers the common image, the pointer and the private bytes. The new value is seen from the next read on.
- R8: Reset (rst_n low, synchronous) drives all rd_data to 0xFF and all absent flags to 1. It clears the pointer and every private byte to 0. The common image is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_tgt | input | 2 | Write target: 0 image, 1 pointer, 2 private byte, 3 none |
| host_port | input | 2 | Port whose private byte is written |
| host_addr | input | 8 | Image address, or private byte select in bits 1:0 |
| host_wdata | input | 8 | Host write data |
| share_en | input | 4 | Per-port enable for presenting the EDID |
| rd_addr | input | 32 | Four read addresses, port p in bits 8p+7:8p |
| rd_data | output | 32 | Four read data bytes, port p in bits 8p+7:8p |
| absent | output | 4 | Per-port not-present flag |

## Verification
A host write and a display-port read can land on the same location in the same cycle. The location may be a common image byte, the pointer itself or a port's private byte. Directed steps provoke each of these three collisions. The random phase steers reads toward the pointer, pointer+1 and 255 while writing to those same targets. Each collision is judged by requiring the pre-write value in the collision cycle and the new value on the following read.

// File: rtl/edid_pkg.sv
// Shared definitions for the multi-port EDID store.
// Assumes byte-wide data throughout.
package edid_pkg;
    localparam int BYTE_W = 8;

    // Host write target selector
    typedef enum logic [1:0] {
        TGT_IMAGE   = 2'd0,
        TGT_POINTER = 2'd1,
        TGT_PRIVATE = 2'd2,
        TGT_NONE    = 2'd3
    } host_tgt_e;

    // Source of a port's returned byte
    typedef enum logic [1:0] {
        SRC_IMAGE = 2'd0,
        SRC_PA0   = 2'd1,
        SRC_PA1   = 2'd2,
        SRC_CKS   = 2'd3
    } src_e;

    // Private bytes owned by one display port
    typedef struct packed {
        logic [BYTE_W-1:0] pa0;
        logic [BYTE_W-1:0] pa1;
        logic [BYTE_W-1:0] cks;
    } priv_t;
endpackage

// File: rtl/edid_shared_ram.sv
// Common EDID image: one write port, NRD independent registered read ports.
// Assumes the content is volatile: no reset, loaded by the host.
// A read and a write to the same address in one cycle returns the old byte.
module edid_shared_ram #(
    parameter int AW  = 8,
    parameter int NRD = 4
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [edid_pkg::BYTE_W-1:0]    wdata,
    input  logic [NRD*AW-1:0]              raddr,
    output logic [NRD*edid_pkg::BYTE_W-1:0] rdata
);
    localparam int DW    = edid_pkg::BYTE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Host load of the common image
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        logic [DW-1:0] q;

        // Registered read for port r
        always_ff @(posedge clk) begin
            q <= mem[raddr[r*AW +: AW]];
        end

        assign rdata[r*DW +: DW] = q;
    end
endmodule

// File: rtl/edid_private_regs.sv
// Substitution pointer and the per-port private bytes, written by the host.
// Assumes host_addr[1:0] picks the private byte; code 3 is ignored.
module edid_private_regs #(
    parameter int NP = 4,
    parameter int AW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  edid_pkg::host_tgt_e         tgt,
    input  logic [$clog2(NP)-1:0]       port,
    input  logic [AW-1:0]               addr,
    input  logic [edid_pkg::BYTE_W-1:0] wdata,
    output logic [AW-1:0]               ptr_o,
    output edid_pkg::priv_t [NP-1:0]    priv_o
);
    import edid_pkg::*;

    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (wr && tgt == TGT_POINTER) begin
            ptr_o <= AW'(wdata);
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_priv
        logic hit;
        assign hit = wr && (tgt == TGT_PRIVATE) && (port == p);

        // Private byte update for port p
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                priv_o[p] <= '0;
            end else if (hit) begin
                case (addr[1:0])
                    2'd0:    priv_o[p].pa0 <= wdata;
                    2'd1:    priv_o[p].pa1 <= wdata;
                    2'd2:    priv_o[p].cks <= wdata;
                    default: priv_o[p]     <= priv_o[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/edid_port_view.sv
// One display port's view: decides, in the read cycle, whether the byte comes
// from the common image or from the port's private bytes, and masks disabled
// ports. Assumes the image read data arrives one cycle after the address.
module edid_port_view #(
    parameter int AW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [AW-1:0]               addr,
    input  logic [AW-1:0]               ptr,
    input  edid_pkg::priv_t             priv,
    input  logic [edid_pkg::BYTE_W-1:0] ram_q,
    output logic [edid_pkg::BYTE_W-1:0] rd_data,
    output logic                        absent
);
    import edid_pkg::*;

    logic [AW-1:0]     ptr_nx;
    src_e              src_d, src_q;
    logic [BYTE_W-1:0] pbyte_d, pbyte_q;
    logic              en_q;

    assign ptr_nx = ptr + AW'(1);

    // Address classification; address 255 wins over a pointer match
    always_comb begin
        src_d   = SRC_IMAGE;
        pbyte_d = priv.cks;
        if (addr == {AW{1'b1}}) begin
            src_d   = SRC_CKS;
            pbyte_d = priv.cks;
        end else if (addr == ptr) begin
            src_d   = SRC_PA0;
            pbyte_d = priv.pa0;
        end else if (addr == ptr_nx) begin
            src_d   = SRC_PA1;
            pbyte_d = priv.pa1;
        end
    end

    // Align selection and private byte with the image read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            src_q   <= SRC_IMAGE;
            pbyte_q <= '0;
        end else begin
            en_q    <= en;
            src_q   <= src_d;
            pbyte_q <= pbyte_d;
        end
    end

    assign rd_data = !en_q ? {BYTE_W{1'b1}} : ((src_q == SRC_IMAGE) ? ram_q : pbyte_q);
    assign absent  = !en_q;
endmodule

// File: rtl/edid_multi_port.sv
// Top of the multi-port EDID store: one common image, host write path,
// and NPORTS concurrent byte-read ports with private byte substitution.
// Assumes the host loads the whole image after power-up.
module edid_multi_port #(
    parameter int NPORTS = 4,
    parameter int AW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [1:0]               host_tgt,
    input  logic [$clog2(NPORTS)-1:0] host_port,
    input  logic [AW-1:0]            host_addr,
    input  logic [7:0]               host_wdata,
    input  logic [NPORTS-1:0]        share_en,
    input  logic [NPORTS*AW-1:0]     rd_addr,
    output logic [NPORTS*8-1:0]      rd_data,
    output logic [NPORTS-1:0]        absent
);
    import edid_pkg::*;

    localparam int DW = BYTE_W;

    host_tgt_e              tgt;
    logic                   img_we;
    logic [AW-1:0]          ptr_q;
    priv_t [NPORTS-1:0]     priv_q;
    logic [NPORTS*DW-1:0]   ram_q;

    assign tgt    = host_tgt_e'(host_tgt);
    assign img_we = host_wr && (tgt == TGT_IMAGE);

    edid_shared_ram #(.AW(AW), .NRD(NPORTS)) u_ram (
        .clk   (clk),
        .we    (img_we),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    edid_private_regs #(.NP(NPORTS), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (host_wr),
        .tgt    (tgt),
        .port   (host_port),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .ptr_o  (ptr_q),
        .priv_o (priv_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        edid_port_view #(.AW(AW)) u_view (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (share_en[p]),
            .addr    (rd_addr[p*AW +: AW]),
            .ptr     (ptr_q),
            .priv    (priv_q[p]),
            .ram_q   (ram_q[p*DW +: DW]),
            .rd_data (rd_data[p*DW +: DW]),
            .absent  (absent[p])
        );
    end
endmodule

// File: rtl/edid_multi_port_chk.sv
// Checker for edid_multi_port, attached by bind. Observes ports plus the
// pointer and private bytes that the register stage drives.
module edid_multi_port_chk #(
    parameter int NP = 4,
    parameter int AW = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NP-1:0]            share_en,
    input logic [NP*AW-1:0]         rd_addr,
    input logic [NP*8-1:0]          rd_data,
    input logic [NP-1:0]            absent,
    input logic [AW-1:0]            ptr,
    input edid_pkg::priv_t [NP-1:0] priv
);
    for (genvar p = 0; p < NP; p++) begin : g_chk
        logic [AW-1:0] a;
        logic [7:0]    d;
        assign a = rd_addr[p*AW +: AW];
        assign d = rd_data[p*8 +: 8];

        AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            absent[p] |-> d == 8'hFF); // R4
        AST_ENABLED_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
            share_en[p] |=> !absent[p]); // R4
        AST_DISABLED_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
            !share_en[p] |=> absent[p]); // R4
        AST_CKS_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
            (share_en[p] && a == {AW{1'b1}}) |=> d == $past(priv[p].cks)); // R3
        AST_PA0_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
            (share_en[p] && a == ptr && a != {AW{1'b1}}) |=> d == $past(priv[p].pa0)); // R2
        AST_PA1_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
            (share_en[p] && a == ptr + AW'(1) && a != {AW{1'b1}}) |=> d == $past(priv[p].pa1)); // R2
    end
endmodule

bind edid_multi_port edid_multi_port_chk #(.NP(NPORTS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .share_en (share_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .absent   (absent),
    .ptr      (ptr_q),
    .priv     (priv_q)
);

// File: tb/sim_edid_multi_port.sv
`timescale 1ns/1ps
module sim_edid_multi_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_tgt = 2'd3;
    logic [1:0]  host_port = 2'd0;
    logic [7:0]  host_addr = 8'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [3:0]  share_en = 4'd0;
    logic [31:0] rd_addr = 32'd0;
    logic [31:0] rd_data;
    logic [3:0]  absent;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model of the host-visible state
    logic [7:0] m_mem [256];
    logic [7:0] m_ptr;
    logic [7:0] m_pa0 [4];
    logic [7:0] m_pa1 [4];
    logic [7:0] m_cks [4];

    edid_multi_port u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_tgt(host_tgt),
        .host_port(host_port), .host_addr(host_addr), .host_wdata(host_wdata),
        .share_en(share_en), .rd_addr(rd_addr), .rd_data(rd_data), .absent(absent)
    );

    always #10 clk = ~clk;

    function automatic logic [8:0] exp_read(input int p, input logic [7:0] a, input logic en);
        if (!en)                 return {1'b1, 8'hFF};
        if (a == 8'hFF)          return {1'b0, m_cks[p]};
        if (a == m_ptr)          return {1'b0, m_pa0[p]};
        if (a == m_ptr + 8'd1)   return {1'b0, m_pa1[p]};
        return {1'b0, m_mem[a]};
    endfunction

    function automatic string class_tag(input logic [7:0] a, input logic en);
        if (!en)                                return "R4";
        if (a == 8'hFF)                         return "R3";
        if (a == m_ptr || a == m_ptr + 8'd1)    return "R2";
        return "R1";
    endfunction

    task automatic model_write(input logic wr, input logic [1:0] tgt, input logic [1:0] hp,
                               input logic [7:0] ha, input logic [7:0] hd);
        if (wr) begin
            case (tgt)
                2'd0: m_mem[ha] = hd;
                2'd1: m_ptr = hd;
                2'd2: case (ha[1:0])
                          2'd0: m_pa0[hp] = hd;
                          2'd1: m_pa1[hp] = hd;
                          2'd2: m_cks[hp] = hd;
                          default: ;
                      endcase
                default: ;
            endcase
        end
    endtask

    task automatic check(input string tag, input int p, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s port %0d: actual absent=%b data=%h expected absent=%b data=%h",
                     tag, p, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    // One cycle: drive after negedge, predict from pre-write state, sample after posedge
    task automatic step(input logic wr, input logic [1:0] tgt, input logic [1:0] hp,
                        input logic [7:0] ha, input logic [7:0] hd, input logic [3:0] en,
                        input logic [31:0] addrs, input string tag);
        logic [8:0] e [4];
        string      t [4];
        @(negedge clk);
        host_wr = wr; host_tgt = tgt; host_port = hp; host_addr = ha; host_wdata = hd;
        share_en = en; rd_addr = addrs;
        for (int p = 0; p < 4; p++) begin
            e[p] = exp_read(p, addrs[p*8 +: 8], en[p]);
            t[p] = (tag == "") ? class_tag(addrs[p*8 +: 8], en[p]) : tag;
        end
        model_write(wr, tgt, hp, ha, hd);
        @(posedge clk);
        #1;
        for (int p = 0; p < 4; p++) check(t[p], p, {absent[p], rd_data[p*8 +: 8]}, e[p]);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] en, input logic [31:0] addrs, input string tag);
        step(1'b0, 2'd3, 2'd0, 8'd0, 8'd0, en, addrs, tag);
    endtask

    task automatic wr(input logic [1:0] tgt, input logic [1:0] hp, input logic [7:0] ha,
                      input logic [7:0] hd, input logic [31:0] addrs, input string tag);
        step(1'b1, tgt, hp, ha, hd, 4'hF, addrs, tag);
    endtask

    function automatic logic [7:0] pick_addr();
        case ($urandom % 5)
            0: return m_ptr;
            1: return m_ptr + 8'd1;
            2: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4711));
        m_ptr = 8'd0;
        for (int p = 0; p < 4; p++) begin m_pa0[p] = 0; m_pa1[p] = 0; m_cks[p] = 0; end
        for (int i = 0; i < 256; i++) m_mem[i] = 8'hXX;

        // R8: reset state
        share_en = 4'hF;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            for (int p = 0; p < 4; p++) check("R8", p, {absent[p], rd_data[p*8 +: 8]}, {1'b1, 8'hFF});
        end
        @(negedge clk); rst_n = 1'b1;

        // R8: pointer and private bytes cleared
        rd(4'hF, {8'd0, 8'hFF, 8'd1, 8'd0}, "R8");

        // Load the common image (ports disabled meanwhile: R4)
        for (int i = 0; i < 256; i++)
            step(1'b1, 2'd0, 2'd0, 8'(i), 8'(i * 7 + 3), 4'h0, {4{8'(i)}}, "R4");

        // R6: pointer and private bytes
        wr(2'd1, 2'd0, 8'd0, 8'h40, {4{8'h10}}, "");
        for (int p = 0; p < 4; p++) begin
            wr(2'd2, 2'(p), 8'd0, 8'(8'h10 + p), {4{8'h11}}, "");
            wr(2'd2, 2'(p), 8'd1, 8'(8'h20 + p), {4{8'h12}}, "");
            wr(2'd2, 2'(p), 8'd2, 8'(8'hC0 + p), {4{8'h13}}, "");
        end

        // R5: concurrent reads, each port its own private bytes
        rd(4'hF, {4{8'h40}}, "R5");
        rd(4'hF, {4{8'h41}}, "R5");
        rd(4'hF, {4{8'hFF}}, "R5");
        rd(4'hF, {8'h40, 8'h41, 8'hFF, 8'h42}, "R5");

        // R6: ignored target and ignored private byte code
        wr(2'd3, 2'd0, 8'h42, 8'h00, {4{8'h00}}, "");
        rd(4'hF, {4{8'h42}}, "R6");
        wr(2'd2, 2'd0, 8'h03, 8'h99, {4{8'h00}}, "");
        rd(4'hF, {8'hFF, 8'h41, 8'h40, 8'hFF}, "R6");

        // R7: same-cycle collisions return old data
        wr(2'd0, 2'd0, 8'h50, 8'hAA, {4{8'h50}}, "R7");
        rd(4'hF, {4{8'h50}}, "R7");
        wr(2'd2, 2'd1, 8'd0, 8'h5A, {4{8'h40}}, "R7");
        rd(4'hF, {4{8'h40}}, "R7");
        wr(2'd2, 2'd2, 8'd2, 8'hE7, {4{8'hFF}}, "R7");
        rd(4'hF, {4{8'hFF}}, "R7");
        wr(2'd1, 2'd0, 8'd0, 8'h60, {4{8'h40}}, "R7");
        rd(4'hF, {8'h60, 8'h61, 8'h40, 8'h41}, "R7");

        // R2/R3: pointer at the top of the range
        wr(2'd1, 2'd0, 8'd0, 8'hFF, {4{8'h00}}, "");
        rd(4'hF, {4{8'hFF}}, "R3");
        rd(4'hF, {4{8'h00}}, "R2");
        wr(2'd1, 2'd0, 8'd0, 8'hFE, {4{8'h00}}, "");
        rd(4'hF, {4{8'hFF}}, "R3");
        rd(4'hF, {4{8'hFE}}, "R2");

        // R4: mixed enables
        rd(4'b0101, {8'hFE, 8'hFF, 8'h10, 8'h20}, "R4");
        rd(4'b1010, {8'hFE, 8'hFF, 8'h10, 8'h20}, "R4");

        // Random phase
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] aa;
            logic [7:0]  ha;
            logic [1:0]  tg;
            for (int p = 0; p < 4; p++) aa[p*8 +: 8] = pick_addr();
            tg = 2'($urandom);
            ha = (tg == 2'd0) ? aa[7:0] : 8'($urandom % 4);
            step(1'($urandom % 3 == 0), tg, 2'($urandom), ha, 8'($urandom),
                 4'($urandom | 32'h5), aa, "");
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule